// File: doc/BRIEF.md
# Dual Down-Counter Timer with Merged Interrupt

This block places two independent down-counting timer channels behind one byte-addressed register port that spans a 4 KB window. Each channel has its own tick-enable input, so the two channels can count at different rates. Each channel also has its own prescaler, a reload register and three counting modes: free-running, periodic and single-shot. The bottom of the window holds the two 32-byte channel register sets. The top holds eight read-only identification words. Reads of every other offset return zero.

Each channel raises a sticky interrupt flag when its counter steps down to zero. Software clears the flag by writing to a clear register. A per-channel enable bit gates the flag, and the two gated flags are combined onto one interrupt line. Read data is a combinational function of the address. Writes take effect on the rising clock edge on which `bus_en` and `bus_wr` are both high.

Top module: `dual_tick_timer`

## Requirements
- R1: Byte offsets 0x000–0x01F reach channel 0. Offsets 0x020–0x03F reach channel 1, with 0x20 removed before the access is decoded. Bits 1:0 of the address are ignored. Inside a window, the word index is: 0 reload, 1 count, 2 control, 3 interrupt clear, 4 raw status, 5 masked status, 6 background reload, 7 unused. Words 3 and 7 read as zero.
- R2: Reads of the word offsets 0xFE0 through 0xFFC return, in address order, 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0, with all upper bits zero. Writes to these offsets change nothing.
- R3: `irq` is high exactly when at least one channel has both its raw flag and its interrupt-enable bit set.
- R4: Reads of 0xF00, 0xF04 and every other offset from 0x040 to 0xFDF return zero. A write outside the two channel windows changes no channel state.
- R5: A write to word 0 sets the reload register and loads the counter in the same edge. A write to word 6 sets only the reload register. A write to word 1 is ignored.
- R6: Control bits: 7 enable, 6 periodic, 5 interrupt enable, 3:2 prescale, 1 wide (32-bit), 0 single-shot. Bit 4 is stored and read back. The counter moves one step only while enable is set, once every 1 (code 0 or 3), 16 (code 1) or 256 (code 2) asserted ticks of its own tick input. A control write restarts the prescale count.
- R7: In periodic mode (bit 6 set, bit 0 clear), a step taken with the counter at zero loads the reload value.
- R8: In free-running mode (bits 6 and 0 clear), a step taken at zero loads 0xFFFF when bit 1 is clear and 0xFFFFFFFF when bit 1 is set. With bit 1 clear, the counter decrements and reads back only its low 16 bits.
- R9: In single-shot mode (bit 0 set, whatever bit 6 holds), the counter stays at zero after reaching it and sets no further flags.
- R10: A step that takes the counter from one to zero sets the raw flag, which reads as bit 0 of word 4. Word 5 reads the raw flag ANDed with control bit 5. A write to word 3 clears the flag unless a set happens on the same edge. After reset, control reads 0x20, count reads 0x0000FFFF and reload reads 0.
- R11: The two channels count and flag independently, each from its own tick input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| tick_a | input | 1 | Tick enable for channel 0 |
| tick_b | input | 1 | Tick enable for channel 1 |
| irq | output | 1 | Merged interrupt |

## Verification
A behavioural model follows both channels edge by edge, and the bench compares it with `irq` after every clock and with register reads after each scenario. Three tick patterns are used: every cycle, every third cycle and every fifth cycle. A steady tick separates the prescale ratios 1, 16 and 256. Sparse ticks show whether the prescaler counts ticks or clock cycles. Running the two channels side by side with different tick patterns shows whether one channel's state leaks into the other.

The counting modes are tried with small reload values, so that the wrap in periodic, free-running 16-bit, free-running 32-bit and single-shot mode each happens within the run. That makes each wrap target visible on its own. Sweeps over the identification and unmapped offsets, and writes aimed at them, check the address map at the port.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    localparam int DATA_W = 32;
    localparam int CTRL_W = 8;
    localparam int PRE_W  = 8;

    localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}};

    // control register layout, bit 7 down to bit 0
    typedef struct packed {
        logic       en;
        logic       periodic;
        logic       ie;
        logic       spare;
        logic [1:0] presc;
        logic       wide;
        logic       oneshot;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{en: 1'b0, periodic: 1'b0, ie: 1'b1, spare: 1'b0,
                                   presc: 2'd0, wide: 1'b0, oneshot: 1'b0};

    // word index inside a channel window
    localparam int W_LOAD   = 0;
    localparam int W_VALUE  = 1;
    localparam int W_CTRL   = 2;
    localparam int W_ICLR   = 3;
    localparam int W_RAW    = 4;
    localparam int W_MASKED = 5;
    localparam int W_BGLOAD = 6;

    typedef enum logic [1:0] {
        MODE_FREE,
        MODE_PERIODIC,
        MODE_ONESHOT
    } count_mode_t;

    typedef struct packed {
        logic              wr_load;
        logic              wr_bg;
        logic              wr_ctrl;
        logic              wr_iclr;
        logic [DATA_W-1:0] data;
    } chan_cmd_t;

    function automatic count_mode_t mode_of(ctrl_t c);
        if (c.oneshot)       return MODE_ONESHOT;
        else if (c.periodic) return MODE_PERIODIC;
        else                 return MODE_FREE;
    endfunction

    // last prescale count before a step is issued
    function automatic logic [PRE_W-1:0] presc_last(logic [1:0] code);
        case (code)
            2'd1:    return PRE_W'(15);
            2'd2:    return PRE_W'(255);
            default: return '0;
        endcase
    endfunction

    function automatic logic [7:0] id_byte(logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h04;
            3'd1:    return 8'h18;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/dtm_prescaler.sv
module dtm_prescaler
    import dtm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       tick,
    input  logic       run,
    input  logic [1:0] code,
    output logic       step
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;
    logic             at_last;

    assign last    = presc_last(code);
    assign at_last = (pre_q == last);
    assign step    = tick & run & at_last;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (tick && run) begin
            pre_q <= at_last ? '0 : pre_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/dtm_channel.sv
module dtm_channel
    import dtm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  chan_cmd_t         cmd,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] load,
    output logic              raw,
    output logic              irq
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cnt_d;
    logic [DATA_W-1:0] load_q;
    logic              raw_q;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] cur;
    logic              step;
    logic              hit_zero;
    count_mode_t       mode;

    dtm_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (cmd.wr_ctrl),
        .tick (tick),
        .run  (ctrl_q.en),
        .code (ctrl_q.presc),
        .step (step)
    );

    assign mask     = ctrl_q.wide ? '1 : NARROW_MASK;
    assign cur      = cnt_q & mask;
    assign mode     = mode_of(ctrl_q);
    assign hit_zero = step && (cur == DATA_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (cmd.wr_load) begin
            cnt_d = cmd.data;
        end else if (step) begin
            if (cur != '0) begin
                cnt_d = cur - DATA_W'(1);
            end else begin
                case (mode)
                    MODE_PERIODIC: cnt_d = load_q;
                    MODE_FREE:     cnt_d = mask;
                    default:       cnt_d = cnt_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            cnt_q  <= '1;
            load_q <= '0;
            raw_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (cmd.wr_load || cmd.wr_bg) begin
                load_q <= cmd.data;
            end
            if (cmd.wr_ctrl) begin
                ctrl_q <= ctrl_t'(cmd.data[CTRL_W-1:0]);
            end
            if (hit_zero) begin
                raw_q <= 1'b1;
            end else if (cmd.wr_iclr) begin
                raw_q <= 1'b0;
            end
        end
    end

    assign ctrl  = ctrl_q;
    assign value = cur;
    assign load  = load_q;
    assign raw   = raw_q;
    assign irq   = raw_q & ctrl_q.ie;

endmodule

// File: rtl/dtm_decode.sv
module dtm_decode
    import dtm_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                NUM_CH    = 2,
    parameter int                WIN_BYTES = 32,
    parameter logic [ADDR_W-1:0] ID_BASE   = 'hFE0
) (
    input  logic                          bus_en,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    input  ctrl_t [NUM_CH-1:0]            ch_ctrl,
    input  logic  [NUM_CH-1:0][DATA_W-1:0] ch_value,
    input  logic  [NUM_CH-1:0][DATA_W-1:0] ch_load,
    input  logic  [NUM_CH-1:0]            ch_raw,
    output chan_cmd_t [NUM_CH-1:0]        ch_cmd,
    output logic [DATA_W-1:0]             bus_rdata
);

    localparam int WIN_LSB = $clog2(WIN_BYTES);
    localparam int WORD_W  = WIN_LSB - 2;
    localparam int SEL_W   = ADDR_W - WIN_LSB;
    localparam int ID_LSB  = 5;

    logic [WORD_W-1:0]             word;
    logic [NUM_CH-1:0][DATA_W-1:0] part;
    logic                          id_hit;
    logic [DATA_W-1:0]             id_data;
    logic [1:0]                    unused_lsb;

    assign word       = bus_addr[WIN_LSB-1:2];
    assign unused_lsb = bus_addr[1:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : gen_win
        logic hit;
        logic wr;

        assign hit = (bus_addr[ADDR_W-1:WIN_LSB] == SEL_W'(c));
        assign wr  = bus_en & bus_wr & hit;

        assign ch_cmd[c].wr_load = wr && (word == WORD_W'(W_LOAD));
        assign ch_cmd[c].wr_bg   = wr && (word == WORD_W'(W_BGLOAD));
        assign ch_cmd[c].wr_ctrl = wr && (word == WORD_W'(W_CTRL));
        assign ch_cmd[c].wr_iclr = wr && (word == WORD_W'(W_ICLR));
        assign ch_cmd[c].data    = bus_wdata;

        always_comb begin
            part[c] = '0;
            if (hit) begin
                case (word)
                    WORD_W'(W_LOAD),
                    WORD_W'(W_BGLOAD): part[c] = ch_load[c];
                    WORD_W'(W_VALUE):  part[c] = ch_value[c];
                    WORD_W'(W_CTRL):   part[c] = DATA_W'(ch_ctrl[c]);
                    WORD_W'(W_RAW):    part[c] = DATA_W'(ch_raw[c]);
                    WORD_W'(W_MASKED): part[c] = DATA_W'(ch_raw[c] & ch_ctrl[c].ie);
                    default:           part[c] = '0;
                endcase
            end
        end
    end

    assign id_hit  = (bus_addr[ADDR_W-1:ID_LSB] == ID_BASE[ADDR_W-1:ID_LSB]);
    assign id_data = DATA_W'(id_byte(bus_addr[ID_LSB-1:2]));

    always_comb begin
        bus_rdata = id_hit ? id_data : '0;
        for (int c = 0; c < NUM_CH; c++) begin
            bus_rdata = bus_rdata | part[c];
        end
    end

endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
    import dtm_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WIN_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_a,
    input  logic              tick_b,
    output logic              irq
);

    localparam int NUM_CH = 2;

    logic      [NUM_CH-1:0]             ticks;
    chan_cmd_t [NUM_CH-1:0]             ch_cmd;
    ctrl_t     [NUM_CH-1:0]             ch_ctrl;
    logic      [NUM_CH-1:0][DATA_W-1:0] ch_value;
    logic      [NUM_CH-1:0][DATA_W-1:0] ch_load;
    logic      [NUM_CH-1:0]             ch_raw;
    logic      [NUM_CH-1:0]             ch_irq;

    assign ticks = {tick_b, tick_a};

    dtm_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_CH    (NUM_CH),
        .WIN_BYTES (WIN_BYTES)
    ) u_dec (
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ch_ctrl   (ch_ctrl),
        .ch_value  (ch_value),
        .ch_load   (ch_load),
        .ch_raw    (ch_raw),
        .ch_cmd    (ch_cmd),
        .bus_rdata (bus_rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : gen_ch
        dtm_channel u_ch (
            .clk   (clk),
            .rst   (rst),
            .tick  (ticks[c]),
            .cmd   (ch_cmd[c]),
            .ctrl  (ch_ctrl[c]),
            .value (ch_value[c]),
            .load  (ch_load[c]),
            .raw   (ch_raw[c]),
            .irq   (ch_irq[c])
        );
    end

    assign irq = |ch_irq;

endmodule

// File: rtl/dtm_checker.sv
module dtm_checker (
    input logic            clk,
    input logic            rst,
    input logic            bus_en,
    input logic            bus_wr,
    input logic [11:0]     bus_addr,
    input logic [31:0]     bus_rdata,
    input logic            irq,
    input logic [1:0]      ch_raw,
    input logic [1:0][7:0] ch_ctrl,
    input logic [31:0]     ch0_value
);

    logic rd_req;
    logic ch0_touch;

    assign rd_req    = bus_en && !bus_wr;
    assign ch0_touch = bus_en && bus_wr && (bus_addr[11:5] == 7'd0);

    // merged line follows the gated channel flags
    assert_irq_merge_R3: assert property (@(posedge clk) disable iff (rst)
        irq == ((ch_raw[0] & ch_ctrl[0][5]) | (ch_raw[1] & ch_ctrl[1][5])));

    assert_gap_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_req && bus_addr >= 12'h040 && bus_addr < 12'hFE0) |-> bus_rdata == 32'd0);

    assert_first_id_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && bus_addr[11:2] == 10'h3F8) |-> bus_rdata == 32'h0000_0004);

    assert_last_id_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && bus_addr[11:2] == 10'h3FF) |-> bus_rdata == 32'h0000_00B1);

    assert_value_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_wr && bus_addr[11:2] == 10'h001 && !ch_ctrl[0][7])
        |=> $stable(ch0_value));

    assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!ch_ctrl[0][7] && !ch0_touch) |=> $stable(ch0_value));

    assert_oneshot_rest_R9: assert property (@(posedge clk) disable iff (rst)
        (ch_ctrl[0][0] && ch0_value == 32'd0 && !ch0_touch) |=> ch0_value == 32'd0);

endmodule

bind dual_tick_timer dtm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .ch_raw    (ch_raw),
    .ch_ctrl   (ch_ctrl),
    .ch0_value (ch_value[0])
);

// File: tb/test_dual_tick_timer.sv
`timescale 1ns/1ps
module test_dual_tick_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_a = 1'b0;
    logic        tick_b = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int per_a = 0;
    int per_b = 0;
    int cyc = 0;

    // behavioural reference state
    int unsigned m_ctrl [2];
    int unsigned m_load [2];
    int unsigned m_cnt  [2];
    int unsigned m_pre  [2];
    bit          m_raw  [2];

    always #2.5 clk = ~clk;

    dual_tick_timer i_dual_tick_timer (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_a(tick_a), .tick_b(tick_b),
        .irq(irq)
    );

    function automatic int unsigned width_mask(int unsigned ctl);
        return ctl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic int unsigned exp_read(logic [11:0] a);
        int unsigned w;
        int c;
        if (a < 12'h040) begin
            c = int'(a[5]);
            w = a[4:2];
            case (w)
                0, 6: return m_load[c];
                1:    return m_cnt[c] & width_mask(m_ctrl[c]);
                2:    return m_ctrl[c];
                4:    return m_raw[c];
                5:    return (m_raw[c] && m_ctrl[c][5]) ? 1 : 0;
                default: return 0;
            endcase
        end else if (a >= 12'hFE0) begin
            case (a[4:2])
                0: return 32'h04; 1: return 32'h18; 2: return 32'h14; 3: return 32'h00;
                4: return 32'h0D; 5: return 32'hF0; 6: return 32'h05; default: return 32'hB1;
            endcase
        end
        return 0;
    endfunction

    // reference model advances on the same edge as the design
    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_ctrl[c] = 32'h20; m_load[c] = 0; m_cnt[c] = 32'hFFFF_FFFF;
                m_pre[c] = 0; m_raw[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                bit tk, en, step, setf, wr;
                int unsigned lim, msk, cur, ncnt, w;
                tk  = (c == 0) ? tick_a : tick_b;
                en  = m_ctrl[c][7];
                lim = (m_ctrl[c][3:2] == 1) ? 15 : (m_ctrl[c][3:2] == 2) ? 255 : 0;
                msk = width_mask(m_ctrl[c]);
                cur = m_cnt[c] & msk;
                step = tk && en && (m_pre[c] == lim);
                setf = step && (cur == 1);
                ncnt = m_cnt[c];
                if (step) begin
                    if (cur != 0) ncnt = cur - 1;
                    else if (m_ctrl[c][0]) ncnt = m_cnt[c];
                    else if (m_ctrl[c][6]) ncnt = m_load[c];
                    else ncnt = msk;
                end
                wr = bus_en && bus_wr && (bus_addr[11:5] == 7'(c));
                w  = bus_addr[4:2];
                if (wr && w == 2) m_pre[c] = 0;
                else if (tk && en) m_pre[c] = (m_pre[c] == lim) ? 0 : m_pre[c] + 1;
                if (wr && w == 0) begin m_load[c] = bus_wdata; ncnt = bus_wdata; end
                if (wr && w == 6) m_load[c] = bus_wdata;
                if (wr && w == 2) m_ctrl[c] = bus_wdata & 32'hFF;
                if (setf) m_raw[c] = 1;
                else if (wr && w == 3) m_raw[c] = 0;
                m_cnt[c] = ncnt;
            end
        end
    end

    // tick patterns
    always @(negedge clk) begin
        cyc++;
        tick_a <= (per_a != 0) && (cyc % per_a == 0);
        tick_b <= (per_b != 0) && (cyc % per_b == 0);
    end

    // interrupt line compared every clock (R3)
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit e;
            e = (m_raw[0] && m_ctrl[0][5]) || (m_raw[1] && m_ctrl[1][5]);
            checks++;
            if (irq !== e) begin
                errors++;
                $display("FAIL R3 irq at cycle %0d: got %0b expected %0b", cyc, irq, e);
            end
        end
    end

    task automatic check(string tag, int unsigned got, int unsigned exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr_reg(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_wr = 0;
    endtask

    task automatic rd_chk(string tag, logic [11:0] a);
        @(negedge clk);
        bus_en = 1; bus_wr = 0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_read(a));
        bus_en = 0;
    endtask

    task automatic rd_fixed(string tag, logic [11:0] a, int unsigned exp);
        @(negedge clk);
        bus_en = 1; bus_wr = 0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        bus_en = 0;
    endtask

    task automatic rd_window(string tag, int c);
        for (int w = 0; w < 8; w++) rd_chk(tag, 12'(c * 32 + w * 4));
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;

        // R10 reset values
        rd_fixed("R10 ctrl reset", 12'h008, 32'h20);
        rd_fixed("R10 count reset", 12'h004, 32'h0000FFFF);
        rd_fixed("R10 reload reset", 12'h000, 32'h0);
        rd_fixed("R10 ch1 ctrl reset", 12'h028, 32'h20);
        check("R3 irq reset", irq, 0);

        // R2 identification words, then a write that must not stick
        for (int i = 0; i < 8; i++) rd_chk("R2 id", 12'(12'hFE0 + i * 4));
        wr_reg(12'hFE0, 32'h55);
        wr_reg(12'hFFC, 32'h0);
        rd_fixed("R2 id after write", 12'hFE0, 32'h04);
        rd_fixed("R2 id last after write", 12'hFFC, 32'hB1);

        // R4 test and unmapped offsets, writes outside windows
        rd_fixed("R4 test ctrl", 12'hF00, 0);
        rd_fixed("R4 test out", 12'hF04, 0);
        rd_fixed("R4 gap", 12'h040, 0);
        rd_fixed("R4 gap high", 12'h800, 0);
        wr_reg(12'h040, 32'h1234);
        wr_reg(12'h048, 32'hFF);
        wr_reg(12'hF00, 32'hFF);
        rd_window("R4 window after stray writes", 0);
        rd_window("R4 window after stray writes", 1);

        // R1 channel 1 reached through the upper window only
        wr_reg(12'h020, 32'h0000_0ABC);
        rd_fixed("R1 ch1 reload", 12'h020, 32'h0ABC);
        rd_fixed("R1 ch0 untouched", 12'h000, 32'h0);
        rd_fixed("R1 address lsbs ignored", 12'h023, 32'h0ABC);

        // R5 background reload and read-only count
        wr_reg(12'h038, 32'h0000_0077);
        rd_fixed("R5 bg reload", 12'h020, 32'h77);
        rd_fixed("R5 count unchanged by bg", 12'h024, 32'h0ABC);
        wr_reg(12'h024, 32'h0000_0001);
        rd_fixed("R5 count write ignored", 12'h024, 32'h0ABC);

        // R7 periodic, wide, div 1, steady ticks
        per_a = 1;
        wr_reg(12'h000, 32'd10);
        wr_reg(12'h008, 32'hE2);
        run(40);
        rd_window("R7 periodic", 0);
        wr_reg(12'h00C, 0);
        rd_chk("R10 flag cleared", 12'h010);
        run(15);
        rd_window("R7 periodic rerun", 0);

        // R6 disabled hold, spare bit read back
        wr_reg(12'h008, 32'h32);
        rd_fixed("R6 spare bit", 12'h008, 32'h32);
        rd_chk("R6 hold read", 12'h004);
        run(20);
        rd_chk("R6 hold after ticks", 12'h004);

        // R8 free-running, 16 bit then 32 bit
        wr_reg(12'h00C, 0);
        wr_reg(12'h000, 32'h0001_0003);
        wr_reg(12'h008, 32'hA0);
        run(6);
        rd_chk("R8 narrow wrap", 12'h004);
        run(30);
        rd_window("R8 narrow run", 0);
        wr_reg(12'h000, 32'd2);
        wr_reg(12'h008, 32'hA2);
        run(6);
        rd_chk("R8 wide wrap", 12'h004);

        // R10 masked status with interrupt enable off
        wr_reg(12'h008, 32'h82);
        wr_reg(12'h000, 32'd3);
        run(10);
        rd_chk("R10 raw with ie off", 12'h010);
        rd_chk("R10 masked with ie off", 12'h014);
        wr_reg(12'h00C, 0);
        rd_chk("R10 raw cleared", 12'h010);

        // R9 single shot on channel 0, periodic bit also set
        wr_reg(12'h000, 32'd4);
        wr_reg(12'h008, 32'hE3);
        run(20);
        rd_window("R9 single shot", 0);
        wr_reg(12'h00C, 0);
        run(20);
        rd_chk("R9 no new flag", 12'h010);
        rd_chk("R9 count rests", 12'h004);

        // R6 prescale by 16 on sparse ticks, single shot on channel 1
        per_b = 3;
        wr_reg(12'h020, 32'd5);
        wr_reg(12'h028, 32'hA5);
        run(100);
        rd_window("R6 div16 partial", 1);
        run(250);
        rd_window("R6 div16 done", 1);
        wr_reg(12'h02C, 0);

        // R6 prescale by 256 on channel 1 with steady ticks
        per_b = 1;
        wr_reg(12'h020, 32'd2);
        wr_reg(12'h028, 32'hEA);
        run(400);
        rd_window("R6 div256 partial", 1);
        run(500);
        rd_window("R6 div256 done", 1);
        wr_reg(12'h02C, 0);

        // R11 both channels in parallel on different tick patterns
        per_a = 1; per_b = 5;
        wr_reg(12'h000, 32'd4);
        wr_reg(12'h020, 32'd4);
        wr_reg(12'h008, 32'hE2);
        wr_reg(12'h028, 32'hE2);
        for (int k = 0; k < 6; k++) begin
            run(7);
            rd_chk("R11 ch0 count", 12'h004);
            rd_chk("R11 ch1 count", 12'h024);
            rd_chk("R11 ch0 flag", 12'h010);
            rd_chk("R11 ch1 flag", 12'h030);
        end
        wr_reg(12'h00C, 0);
        run(3);
        rd_chk("R11 ch1 flag kept", 12'h030);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule